// File: doc/BRIEF.md
# Invert-Based Integer ALU with Function Decoder

This block is a combinational integer arithmetic-logic unit paired with the decoder that selects its function. A 2-bit operation class from the main instruction decoder and a 6-bit function code from the instruction word go into the decoder. The decoder produces a 4-bit control word. That word holds an invert flag for operand A, an invert flag for operand B and a 2-bit selector. The selector picks the AND, OR, sum or signed-less-than path.

All six functions come from that one control word. Subtraction inverts B and sets the carry-in. NOR is the AND of both inverted operands. Set-less-than takes the sign of A minus B and corrects it for overflow. Beside the result, the block reports a zero flag and a signed-overflow flag. It also raises a flag when the function request is not recognised. The operand width is a parameter, and a second parameter chooses between two adder implementations.

Top module: `alu_invert_core`

## Requirements
- R1: The control word `ctrl` has this layout: bit 3 inverts A, bit 2 inverts B and bits 1:0 form the selector. Selector 00 is AND, 01 is OR, 10 is sum and 11 is less-than. When `alu_op` is 00, `ctrl` is 0010 (add), whatever `funct` holds.
- R2: When `alu_op` is 01, `ctrl` is 0110 (subtract), whatever `funct` holds.
- R3: When `alu_op` is 10, `funct` is decoded as follows: 0x20 gives 0010, 0x22 gives 0110, 0x24 gives 0000, 0x25 gives 0001, 0x2A gives 0111 and 0x27 gives 1100.
- R4: When `alu_op` is 11, or when `alu_op` is 10 with any other `funct`, `ctrl` is 0010 and `bad_fn` is 1. In every other case `bad_fn` is 0.
- R5: Selector 00 without inversion yields A AND B. Selector 01 without inversion yields A OR B.
- R6: Add yields A plus B modulo 2^WIDTH. Subtract yields A plus the inverted B plus 1, which equals A minus B modulo 2^WIDTH.
- R7: Set-less-than yields 1 in bit 0 when A is less than B as signed numbers, and 0 otherwise. All higher result bits are 0, and the answer stays correct when A minus B overflows.
- R8: Control 1100 yields the NOR of A and B.
- R9: `ovf` is 1 only when the selector is 10 and both effective operands share a sign that the sum does not have. For every other selector, `ovf` is 0.
- R10: `zero` is 1 exactly when every result bit is 0, for every function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function code, decoded only when alu_op is 10 |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| ctrl | output | 4 | Decoded control word {invert A, invert B, selector} |
| result | output | WIDTH | Function result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the sum path |
| bad_fn | output | 1 | Unrecognised function request, add performed |

## Verification
The embedded assertions are evaluated whenever the inputs are known. They check four things: an unrecognised request always falls back to the add control word, overflow never appears outside the sum selector, the less-than result never sets an upper bit, and the subtract control word always yields the true difference across the decoder/adder boundary. The bench scenarios show the rest. These are the exact decode table for every function code, signed less-than at the overflow boundaries, wrap-around of add and subtract, overflow in both signs, NOR and the zero flag on logic results. Each scenario is compared against a reference computed independently in the bench.

// File: rtl/alu_inv_pkg.sv
package alu_inv_pkg;
   typedef logic [1:0] sel_t;
   localparam sel_t SEL_AND  = 2'b00;
   localparam sel_t SEL_OR   = 2'b01;
   localparam sel_t SEL_SUM  = 2'b10;
   localparam sel_t SEL_LESS = 2'b11;

   typedef struct packed {
      logic inv_a;
      logic inv_b;
      sel_t sel;
   } ctrl_t;

   localparam ctrl_t CW_AND = 4'b0000;
   localparam ctrl_t CW_OR  = 4'b0001;
   localparam ctrl_t CW_ADD = 4'b0010;
   localparam ctrl_t CW_SUB = 4'b0110;
   localparam ctrl_t CW_SLT = 4'b0111;
   localparam ctrl_t CW_NOR = 4'b1100;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_NOR = 6'h27;
   localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
   import alu_inv_pkg::*;
(
   input  logic [1:0] alu_op,
   input  logic [5:0] funct,
   output ctrl_t      ctrl,
   output logic       bad_fn
);
   always_comb begin
      ctrl   = CW_ADD;
      bad_fn = 1'b0;
      case (alu_op)
         2'b00: ctrl = CW_ADD;
         2'b01: ctrl = CW_SUB;
         2'b10: begin
            case (funct)
               FN_ADD:  ctrl = CW_ADD;
               FN_SUB:  ctrl = CW_SUB;
               FN_AND:  ctrl = CW_AND;
               FN_OR:   ctrl = CW_OR;
               FN_SLT:  ctrl = CW_SLT;
               FN_NOR:  ctrl = CW_NOR;
               default: bad_fn = 1'b1;
            endcase
         end
         default: bad_fn = 1'b1;
      endcase
   end
endmodule

// File: rtl/alu_inv_adder.sv
module alu_inv_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             inv_a,
   input  logic             inv_b,
   output logic [WIDTH-1:0] a_eff,
   output logic [WIDTH-1:0] b_eff,
   output logic [WIDTH-1:0] sum,
   output logic             ovf_raw,
   output logic             less
);
   localparam int MSB = WIDTH - 1;

   assign a_eff = inv_a ? ~opa : opa;
   assign b_eff = inv_b ? ~opb : opb;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = inv_b;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a_eff[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a_eff[i] & b_eff[i]) | (cy[i] & (a_eff[i] ^ b_eff[i]));
         end
         assign ovf_raw = cy[WIDTH] ^ cy[MSB];
      end else begin : g_behav
         assign sum     = a_eff + b_eff + {{(WIDTH-1){1'b0}}, inv_b};
         assign ovf_raw = (a_eff[MSB] == b_eff[MSB]) && (sum[MSB] != a_eff[MSB]);
      end
   endgenerate

   assign less = sum[MSB] ^ ovf_raw;
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
   import alu_inv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  sel_t             sel,
   input  logic [WIDTH-1:0] a_eff,
   input  logic [WIDTH-1:0] b_eff,
   input  logic [WIDTH-1:0] sum,
   input  logic             less,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   always_comb begin
      case (sel)
         SEL_AND: result = a_eff & b_eff;
         SEL_OR:  result = a_eff | b_eff;
         SEL_SUM: result = sum;
         default: result = {{(WIDTH-1){1'b0}}, less};
      endcase
   end

   assign zero = ~|result;
endmodule

// File: rtl/alu_invert_core.sv
module alu_invert_core
   import alu_inv_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [1:0]       alu_op,
   input  logic [5:0]       funct,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [3:0]       ctrl,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             ovf,
   output logic             bad_fn
);
   generate
      if (WIDTH < 2) begin : g_width_check
         $error("alu_invert_core: WIDTH must be at least 2");
      end
   endgenerate

   ctrl_t            cw;
   logic [WIDTH-1:0] a_eff, b_eff, sum;
   logic             ovf_raw, less;

   alu_fn_decode u_dec (
      .alu_op (alu_op),
      .funct  (funct),
      .ctrl   (cw),
      .bad_fn (bad_fn)
   );

   alu_inv_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .opa     (opa),
      .opb     (opb),
      .inv_a   (cw.inv_a),
      .inv_b   (cw.inv_b),
      .a_eff   (a_eff),
      .b_eff   (b_eff),
      .sum     (sum),
      .ovf_raw (ovf_raw),
      .less    (less)
   );

   alu_result_mux #(.WIDTH(WIDTH)) u_mux (
      .sel    (cw.sel),
      .a_eff  (a_eff),
      .b_eff  (b_eff),
      .sum    (sum),
      .less   (less),
      .result (result),
      .zero   (zero)
   );

   assign ctrl = cw;
   assign ovf  = (cw.sel == SEL_SUM) & ovf_raw;

   always_comb begin
      if (!$isunknown({alu_op, funct, opa, opb})) begin
         assert_invalid_is_add_R4: assert (!bad_fn || cw == CW_ADD);
         assert_no_overflow_R9: assert (cw.sel == SEL_SUM || !ovf);
         assert_slt_upper_R7: assert (cw.sel != SEL_LESS || result[WIDTH-1:1] == '0);
         assert_sub_diff_R6: assert (cw != CW_SUB || result == opa - opb);
      end
   end
endmodule

// File: tb/sim_alu_invert_core.sv
module sim_alu_invert_core;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [1:0]   alu_op = '0;
   logic [5:0]   funct = '0;
   logic [W-1:0] opa = '0, opb = '0;
   logic [3:0]   ctrl;
   logic [W-1:0] result;
   logic         zero, ovf, bad_fn;

   always #4 clk = ~clk;

   alu_invert_core #(.WIDTH(W)) u0 (
      .alu_op(alu_op), .funct(funct), .opa(opa), .opb(opb),
      .ctrl(ctrl), .result(result), .zero(zero), .ovf(ovf), .bad_fn(bad_fn)
   );

   typedef struct {
      logic [3:0]   ctrl;
      logic [W-1:0] res;
      logic         zero, ovf, bad;
      string        req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   function automatic exp_t model(logic [1:0] op, logic [5:0] fn,
                                  logic [W-1:0] a, logic [W-1:0] b, string req);
      exp_t e;
      logic [W-1:0] d;
      e.req = req; e.bad = 0; e.ovf = 0;
      if (op == 2'b00) e.ctrl = 4'b0010;
      else if (op == 2'b01) e.ctrl = 4'b0110;
      else if (op == 2'b11) begin e.ctrl = 4'b0010; e.bad = 1; end
      else begin
         case (fn)
            6'h20: e.ctrl = 4'b0010;
            6'h22: e.ctrl = 4'b0110;
            6'h24: e.ctrl = 4'b0000;
            6'h25: e.ctrl = 4'b0001;
            6'h2A: e.ctrl = 4'b0111;
            6'h27: e.ctrl = 4'b1100;
            default: begin e.ctrl = 4'b0010; e.bad = 1; end
         endcase
      end
      case (e.ctrl)
         4'b0000: e.res = a & b;
         4'b0001: e.res = a | b;
         4'b1100: e.res = ~(a | b);
         4'b0111: e.res = ($signed(a) < $signed(b)) ? 1 : 0;
         4'b0110: begin
            d = a - b; e.res = d;
            e.ovf = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
         end
         default: begin
            d = a + b; e.res = d;
            e.ovf = (a[W-1] == b[W-1]) && (d[W-1] != a[W-1]);
         end
      endcase
      e.zero = (e.res == 0);
      return e;
   endfunction

   task automatic drive(logic [1:0] op, logic [5:0] fn,
                        logic [W-1:0] a, logic [W-1:0] b, string req);
      @(posedge clk); #1;
      alu_op = op; funct = fn; opa = a; opb = b;
      exp_q.push_back(model(op, fn, a, b, req));
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (ctrl !== e.ctrl || result !== e.res || zero !== e.zero ||
             ovf !== e.ovf || bad_fn !== e.bad) begin
            n_fail++;
            $display("FAIL %s: ctrl=%b res=%h z=%b v=%b bad=%b expected ctrl=%b res=%h z=%b v=%b bad=%b",
                     e.req, ctrl, result, zero, ovf, bad_fn,
                     e.ctrl, e.res, e.zero, e.ovf, e.bad);
         end
      end
   end

   initial begin
      // idle inputs: add of zeros, zero flag set (R1, R10)
      drive(2'b00, 6'h00, 0, 0, "R1 idle");
      drive(2'b00, 6'h22, 32'd7, 32'd5, "R1 forced add ignores funct");
      drive(2'b01, 6'h20, 32'd7, 32'd5, "R2 forced sub ignores funct");
      drive(2'b01, 6'h24, 32'd5, 32'd5, "R2 sub equal gives zero R10");
      drive(2'b10, 6'h20, 32'h1234_5678, 32'h0FED_CBA9, "R3 funct add");
      drive(2'b10, 6'h22, 32'd3, 32'd10, "R3 funct sub wraps R6");
      drive(2'b10, 6'h24, 32'hF0F0_FF00, 32'h0FF0_F0F0, "R5 and");
      drive(2'b10, 6'h24, 32'hF0F0_0000, 32'h0F0F_FFFF, "R5 and zero R10");
      drive(2'b10, 6'h25, 32'hA000_0005, 32'h0500_00A0, "R5 or");
      drive(2'b10, 6'h27, 32'hF0F0_1234, 32'h0000_8001, "R8 nor");
      drive(2'b10, 6'h27, 32'hFFFF_0000, 32'h0000_FFFF, "R8 nor zero R10");
      drive(2'b11, 6'h20, 32'd9, 32'd1, "R4 class 11 invalid");
      drive(2'b10, 6'h21, 32'd9, 32'd1, "R4 unlisted funct");
      drive(2'b10, 6'h3F, 32'hFFFF_FFFF, 32'd1, "R4 unlisted funct wrap R6");
      drive(2'b10, 6'h20, 32'hFFFF_FFFF, 32'd1, "R6 add wrap to zero");
      drive(2'b10, 6'h20, 32'h7FFF_FFFF, 32'd1, "R9 add positive overflow");
      drive(2'b10, 6'h20, 32'h8000_0000, 32'h8000_0000, "R9 add negative overflow");
      drive(2'b10, 6'h22, 32'h8000_0000, 32'd1, "R9 sub overflow");
      drive(2'b10, 6'h22, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9 sub overflow pos");
      drive(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd1, "R7 slt negative lt");
      drive(2'b10, 6'h2A, 32'd1, 32'hFFFF_FFFF, "R7 slt not lt");
      drive(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, "R7 slt overflow corrected R9");
      drive(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, "R7 slt overflow ge");
      drive(2'b10, 6'h2A, 32'd42, 32'd42, "R7 slt equal");
      drive(2'b10, 6'h25, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9 or no overflow");
      for (int i = 0; i < 40; i++) begin
         logic [5:0] fl [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h27};
         drive(2'b10, fl[i % 6], 32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 ^ (i * 32'h0101_0101),
               "R3 sweep");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual done=0 expected done=1");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule